// File: doc/BRIEF.md
# Scanline Interrupt Down-Counter

This block raises a level interrupt toward the CPU once a programmable number of scanline ticks has gone by. Software programs a reload value, asks for a reload, and arms the interrupt through a small write port. The write port selects one of four actions by a 2-bit select code. Scanline detection happens elsewhere. The block sees only `tick`, a single-cycle pulse per scanline that arrives already qualified.

An 8-bit down-counter runs on the ticks. When the counter is zero, or when a reload has been requested, a tick copies the stored reload value into the counter. Otherwise a tick decrements the counter. A tick that moves the counter from a nonzero value to zero raises the interrupt, provided the interrupt is armed. The interrupt then stays raised until software acknowledges it. The reload value always has its lowest bit cleared.

No data moves through this block, so it has no valid/ready handshake. Every pin is a plain control pin. A write takes effect in the cycle where `wr_en` is high, and the block can never refuse it.

Top module: `scanline_irq`

## Requirements
- R1: Reset clears the counter, the stored reload value, the reload request, the arm flag and `irq`. After reset, ticks alone never raise `irq`.
- R2: A write with `wr_sel` = 0 stores `wr_data` as the reload value with bit 0 forced to 0. Writing 2k+1 gives the same tick count to the interrupt as writing 2k.
- R3: A write with `wr_sel` = 1 only marks a reload as pending. The counter keeps its value until the next tick, and that tick loads the reload value in place of a decrement.
- R4: On a tick, if the counter is zero or a reload is pending, the counter takes the reload value and the pending mark clears. Otherwise the counter decreases by one. Starting from zero with reload value L ≥ 2, the interrupt comes on tick L+1.
- R5: `irq` is set by a tick that takes the counter from nonzero to zero while the arm flag is set. This includes a pending reload of a zero reload value. A reload value of 0 loaded from a zero counter never sets it.
- R6: A write with `wr_sel` = 2 clears the arm flag and drops `irq`.
- R7: A write with `wr_sel` = 3 sets the arm flag. It does not raise `irq` for a zero crossing that happened while the flag was clear.
- R8: Once set, `irq` stays high through further ticks until a `wr_sel` = 2 write or reset.
- R9: When a write and a tick share a cycle, the tick sees the state with the write already applied. This covers a new reload value, a new reload request, and an arm flag that was just set or just cleared.
- R10: `irq` is registered. It changes on the clock edge that samples the causing tick or write, and never rises without a tick in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one action per cycle |
| wr_sel | input | 2 | Action: 0 reload value, 1 reload request, 2 disarm and acknowledge, 3 arm |
| wr_data | input | CNT_W | Reload value for `wr_sel` = 0 |
| tick | input | 1 | One-cycle scanline pulse |
| irq | output | 1 | Level interrupt request |

## Verification
Every result appears on the clock edge that samples its cause. A write sampled at an edge changes the state that the tick at that same edge uses. The `irq` produced by a tick is visible just after that edge. The bench drives the inputs on the falling edge and reads `irq` on the next falling edge, so each check sits half a cycle after the edge that should have produced it. The bench also checks `irq` one falling edge before the expected tick, which confirms that `irq` does not rise early. A sweep over every even reload value measures how many ticks pass before `irq` rises, and compares that count with L+1.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  typedef enum logic [1:0] {
    SEL_LATCH  = 2'd0,
    SEL_RELOAD = 2'd1,
    SEL_ACK    = 2'd2,
    SEL_ARM    = 2'd3
  } sel_e;
endpackage

// File: rtl/irqc_regs.sv
module irqc_regs import irqc_pkg::*; #(
  parameter int W    = 8,
  parameter int DROP = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [1:0]   wr_sel,
  input  logic [W-1:0] wr_data,
  input  logic         tick,
  output logic [W-1:0] latch_eff,
  output logic         reload_eff,
  output logic         enable_eff,
  output logic         ack_hit
);
  logic [W-1:0] latch_q;
  logic [W-1:0] masked;
  logic         reload_q;
  logic         enable_q;
  logic         hit_latch;
  logic         hit_reload;
  logic         hit_arm;

  assign hit_latch  = wr_en && (wr_sel == SEL_LATCH);
  assign hit_reload = wr_en && (wr_sel == SEL_RELOAD);
  assign hit_arm    = wr_en && (wr_sel == SEL_ARM);
  assign ack_hit    = wr_en && (wr_sel == SEL_ACK);

  generate
    if (DROP == 0) begin : g_keep
      assign masked = wr_data;
    end else begin : g_drop
      assign masked = {wr_data[W-1:DROP], {DROP{1'b0}}};
    end
  endgenerate

  // Write-first view of the state, used by the tick in the same cycle
  assign latch_eff  = hit_latch ? masked : latch_q;
  assign reload_eff = reload_q | hit_reload;
  always_comb begin
    enable_eff = enable_q;
    if (hit_arm)      enable_eff = 1'b1;
    else if (ack_hit) enable_eff = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q  <= '0;
      reload_q <= 1'b0;
      enable_q <= 1'b0;
    end else begin
      latch_q  <= latch_eff;
      reload_q <= reload_eff & ~tick;
      enable_q <= enable_eff;
    end
  end
endmodule

// File: rtl/irqc_count.sv
module irqc_count #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [W-1:0] latch_eff,
  input  logic         reload_eff,
  output logic         zero_hit
);
  localparam logic [W-1:0] ZERO = '0;
  localparam logic [W-1:0] ONE  = W'(1);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_nx;

  always_comb begin
    cnt_nx = cnt_q;
    if (tick) begin
      if ((cnt_q == ZERO) || reload_eff) cnt_nx = latch_eff;
      else                               cnt_nx = cnt_q - ONE;
    end
  end

  assign zero_hit = tick && (cnt_q != ZERO) && (cnt_nx == ZERO);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= ZERO;
    else        cnt_q <= cnt_nx;
  end
endmodule

// File: rtl/irqc_flag.sv
module irqc_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_req,
  input  logic clr_req,
  output logic flag
);
  logic flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (clr_req) flag_q <= 1'b0;
    else if (set_req) flag_q <= 1'b1;
  end

  assign flag = flag_q;
endmodule

// File: rtl/scanline_irq.sv
module scanline_irq #(
  parameter int CNT_W    = 8,
  parameter int LSB_DROP = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             tick,
  output logic             irq
);
  logic [CNT_W-1:0] latch_eff;
  logic             reload_eff;
  logic             enable_eff;
  logic             ack_hit;
  logic             zero_hit;

  irqc_regs #(.W(CNT_W), .DROP(LSB_DROP)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_sel     (wr_sel),
    .wr_data    (wr_data),
    .tick       (tick),
    .latch_eff  (latch_eff),
    .reload_eff (reload_eff),
    .enable_eff (enable_eff),
    .ack_hit    (ack_hit)
  );

  irqc_count #(.W(CNT_W)) u_count (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .latch_eff  (latch_eff),
    .reload_eff (reload_eff),
    .zero_hit   (zero_hit)
  );

  irqc_flag u_flag (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_req (zero_hit && enable_eff),
    .clr_req (ack_hit),
    .flag    (irq)
  );
endmodule

// File: rtl/scanline_irq_sva.sv
module scanline_irq_sva #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [1:0]       wr_sel,
  input logic [CNT_W-1:0] wr_data,
  input logic             tick,
  input logic             irq
);
  logic ack_w;
  logic arm_w;
  logic arm_seen_q;
  logic arm_seen_nx;

  assign ack_w = wr_en && (wr_sel == 2'd2);
  assign arm_w = wr_en && (wr_sel == 2'd3);

  // Port-level model of the arm flag
  always_comb begin
    arm_seen_nx = arm_seen_q;
    if (arm_w)      arm_seen_nx = 1'b1;
    else if (ack_w) arm_seen_nx = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) arm_seen_q <= 1'b0;
    else        arm_seen_q <= arm_seen_nx;
  end

  p_ack_drops_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ack_w |=> !irq);

  p_irq_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !ack_w) |=> irq);

  p_rise_needs_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(tick));

  p_rise_needs_arm_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(arm_seen_nx));

  p_quiet_without_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !ack_w) |=> $stable(irq));
endmodule

bind scanline_irq scanline_irq_sva #(.CNT_W(CNT_W)) u_sva (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_en   (wr_en),
  .wr_sel  (wr_sel),
  .wr_data (wr_data),
  .tick    (tick),
  .irq     (irq)
);

// File: tb/scanline_irq_test.sv
module scanline_irq_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic       tick = 1'b0;
  logic       irq;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  localparam logic [1:0] S_LATCH = 2'd0;
  localparam logic [1:0] S_RELOAD = 2'd1;
  localparam logic [1:0] S_ACK = 2'd2;
  localparam logic [1:0] S_ARM = 2'd3;

  always #5 clk = ~clk;

  scanline_irq uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .tick(tick), .irq(irq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic tk();
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic wr_tk(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d; tick = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; tick = 1'b0;
  endtask

  // Ticks until irq is seen; 0 when it never rises within lim
  task automatic ticks_to_irq(input int lim, output int n);
    n = 0;
    for (int i = 1; i <= lim; i++) begin
      tk();
      if (irq) begin n = i; break; end
    end
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int n;
    do_reset();
    check(irq == 1'b0, "R1 reset state", irq, 0);

    // R1: counter and latch cleared -> no interrupt from ticks after arming
    wr(S_ARM, 8'd0);
    ticks_to_irq(10, n);
    check(n == 0, "R1 cleared latch never fires", n, 0);

    // R1: reset clears arm flag
    wr(S_LATCH, 8'd4); tk(); tk();
    do_reset();
    wr(S_LATCH, 8'd2); tk(); tk(); tk();
    check(irq == 1'b0, "R1 arm cleared by reset", irq, 0);

    // R2/R4/R5 sweep over reload values, odd writes lose bit 0
    for (int k = 0; k < 128; k++) begin
      int lval = 2 * k;
      int exp = (lval == 0) ? 0 : lval + 1;
      do_reset();
      wr(S_LATCH, (k % 2 == 1) ? 8'(lval + 1) : 8'(lval));
      wr(S_ARM, 8'd0);
      ticks_to_irq((lval == 0) ? 8 : lval + 1, n);
      check(n == exp, (k % 2 == 1) ? "R2 odd value ticks" : "R4 R5 ticks to irq", n, exp);
      if (lval == 4) begin
        tk(); tk(); tk();
        check(irq == 1'b1, "R8 irq held across ticks", irq, 1);
      end
    end

    // R3: reload deferred to next tick
    do_reset();
    wr(S_LATCH, 8'd2); wr(S_ARM, 8'd0);
    tk(); tk();
    wr(S_LATCH, 8'd6); wr(S_RELOAD, 8'd0);
    tk();
    check(irq == 1'b0, "R3 reload tick no irq", irq, 0);
    ticks_to_irq(10, n);
    check(n == 6, "R3 ticks after deferred reload", n, 6);

    // R5: pending reload of zero from nonzero counter fires; R10 timing
    do_reset();
    wr(S_LATCH, 8'd4); wr(S_ARM, 8'd0);
    tk(); tk();
    wr(S_LATCH, 8'd0); wr(S_RELOAD, 8'd0);
    check(irq == 1'b0, "R10 no irq before tick", irq, 0);
    tk();
    check(irq == 1'b1, "R5 reload to zero fires", irq, 1);

    // R6/R7: disarmed crossing ignored, arming is not retroactive
    do_reset();
    wr(S_LATCH, 8'd2);
    tk(); tk(); tk();
    check(irq == 1'b0, "R6 disarmed crossing silent", irq, 0);
    wr(S_ARM, 8'd0);
    check(irq == 1'b0, "R7 arm not retroactive", irq, 0);
    ticks_to_irq(5, n);
    check(n == 3, "R7 armed crossing fires", n, 3);

    // R6: acknowledge drops irq and disarms
    wr(S_ACK, 8'd0);
    check(irq == 1'b0, "R6 ack drops irq", irq, 0);
    tk(); tk(); tk();
    check(irq == 1'b0, "R6 ack leaves disarmed", irq, 0);

    // R9: ack in the same cycle as a zero crossing
    do_reset();
    wr(S_LATCH, 8'd2); wr(S_ARM, 8'd0);
    tk(); tk();
    wr_tk(S_ACK, 8'd0);
    check(irq == 1'b0, "R9 ack with crossing", irq, 0);
    tk(); tk();
    wr_tk(S_ARM, 8'd0);
    check(irq == 1'b1, "R9 arm with crossing", irq, 1);

    // R9: reload request with tick
    do_reset();
    wr(S_LATCH, 8'd4); wr(S_ARM, 8'd0);
    tk(); tk();
    wr(S_LATCH, 8'd8);
    wr_tk(S_RELOAD, 8'd0);
    ticks_to_irq(12, n);
    check(n == 8, "R9 reload with tick", n, 8);

    // R9: new reload value with tick from zero counter
    do_reset();
    wr(S_ARM, 8'd0);
    wr_tk(S_LATCH, 8'd6);
    ticks_to_irq(10, n);
    check(n == 6, "R9 latch with tick", n, 6);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule